// File: doc/BRIEF.md
# Single-Bus Multicycle Accumulator Processor

This block is a small stored-program processor whose program and data share one memory, reached through a single bus. Each instruction is two bytes: an opcode byte, then an address byte. The controller moves through its phases in a fixed order: instruction fetch, decode, operand fetch, execute and write result. The instruction fetch itself is two bus reads, one for each byte. Because only one bus exists, the operand read can never overlap an instruction read. It always runs as its own serialized bus transaction.

The execution unit holds a program counter, an instruction register, a latched address byte and a two-entry register file of data-width registers. An ALU performs load, add, subtract, AND, OR and XOR with memory as the second operand. Stores and jumps complete the instruction set. Every bus transaction is a request/acknowledge exchange. An opcode the decoder does not know stops the processor with a sticky fault indication.

Top module: `acc_cpu`

## Requirements
- R1: After reset the program counter and both registers are 0. The first bus request is a read at address 0 with `fault` low.
- R2: Instruction fetch is two read transactions, at PC and then PC+1. The PC advances by one after each fetched byte.
- R3: While `bus_req` is high and `bus_ack` is low, the address, write flag and write data are held stable. In the cycle after an acknowledged transaction, `bus_req` is low.
- R4: For an instruction that reads memory, the operand read is a separate transaction issued only after both instruction bytes have been read. Its address is the instruction's address byte.
- R5: Opcode 0x73 adds the byte at the operand address to register 1 and writes the sum back to register 1, modulo 2^8.
- R6: Opcode encoding: bits [7:4] select the operation, bits [3:1] must be 001, and bit 0 selects register 0 or 1. The operations are load=1, store=2, jump=4, add=7, subtract=8, AND=9, OR=0xA and XOR=0xB.
- R7: Subtract forms register minus memory byte in two's complement, wrapping modulo 2^8.
- R8: AND, OR and XOR combine the register with the memory byte bitwise and store the result in the register.
- R9: Load copies the memory byte into the register. Store issues one write transaction of the register value to the address byte during the write-result phase and reads no operand.
- R10: Jump loads the PC with the address byte and issues no operand read.
- R11: An opcode that violates R6 raises `fault`. After that, no further bus request is issued, and `fault` stays high until reset.
- R12: An instruction writes only the register selected by its bit 0, and the other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | output | 1 | Transaction request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transaction acknowledge |
| fault | output | 1 | Sticky undefined-opcode halt flag |

## Verification
Two events can fall in the same cycle. One is the acknowledge that completes a transaction. The other is the controller's move into a phase that wants the bus at once, for example the operand read straight after the address-byte read, or the next opcode fetch straight after a store. Programs built from back-to-back memory instructions, run against a memory that acknowledges one cycle after each request, provoke this collision on every instruction. The bench logs every acknowledged transaction and checks the exact order of addresses and read/write kinds. It also flags any cycle in which a request is high directly after an acknowledge.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam logic [3:0] OPC_LD  = 4'h1;
    localparam logic [3:0] OPC_ST  = 4'h2;
    localparam logic [3:0] OPC_JMP = 4'h4;
    localparam logic [3:0] OPC_ADD = 4'h7;
    localparam logic [3:0] OPC_SUB = 4'h8;
    localparam logic [3:0] OPC_AND = 4'h9;
    localparam logic [3:0] OPC_OR  = 4'hA;
    localparam logic [3:0] OPC_XOR = 4'hB;

    typedef enum logic [2:0] {
        PH_FETCH_OP,
        PH_FETCH_ADR,
        PH_DECODE,
        PH_OPERAND,
        PH_EXECUTE,
        PH_WRITE,
        PH_HALT
    } phase_t;

    typedef struct packed {
        logic [3:0] op;
        logic       rsel;
        logic       valid;
        logic       needs_operand;
        logic       writes_reg;
        logic       writes_mem;
        logic       is_jump;
    } decode_t;

    function automatic decode_t decode_op(input logic [7:0] opbyte);
        decode_t d;
        d.op            = opbyte[7:4];
        d.rsel          = opbyte[0];
        d.valid         = 1'b0;
        d.needs_operand = 1'b0;
        d.writes_reg    = 1'b0;
        d.writes_mem    = 1'b0;
        d.is_jump       = 1'b0;
        if (opbyte[3:1] == 3'b001) begin
            case (opbyte[7:4])
                OPC_LD, OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_XOR: begin
                    d.valid         = 1'b1;
                    d.needs_operand = 1'b1;
                    d.writes_reg    = 1'b1;
                end
                OPC_ST: begin
                    d.valid      = 1'b1;
                    d.writes_mem = 1'b1;
                end
                OPC_JMP: begin
                    d.valid   = 1'b1;
                    d.is_jump = 1'b1;
                end
                default: d.valid = 1'b0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op)
            OPC_ADD: y = a + b;
            OPC_SUB: y = a + (~b) + DW'(1);
            OPC_AND: y = a & b;
            OPC_OR:  y = a | b;
            OPC_XOR: y = a ^ b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 2,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (waddr == RW'(g)))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/cpu_bus_port.sv
module cpu_bus_port #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          we_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ack,
    output logic          done
);
    logic gap;

    assign bus_req   = go && !gap;
    assign bus_we    = we_in;
    assign bus_addr  = addr_in;
    assign bus_wdata = wdata_in;
    assign done      = bus_req && bus_ack;

    always_ff @(posedge clk) begin
        if (rst) gap <= 1'b0;
        else     gap <= done;
    end

    // R3: request held with stable address and kind until acknowledged
    p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R3: one idle cycle after every completed transaction
    p_release_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> !bus_req);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import cpu_pkg::*;
#(
    parameter int AW   = 8,
    parameter int DW   = 8,
    parameter int NREG = 2
) (
    input  logic          clk,
    input  logic          rst,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic          fault
);
    localparam int RW = (NREG > 1) ? $clog2(NREG) : 1;

    phase_t        phase;
    logic [AW-1:0] pc;
    logic [7:0]    ir;
    logic [7:0]    adr;
    logic [DW-1:0] opnd;
    logic [DW-1:0] res;
    decode_t       dec;

    logic          go, go_we, done;
    logic [AW-1:0] go_addr;
    logic [DW-1:0] racc, alu_y;
    logic          rf_we;

    assign dec = decode_op(ir);

    cpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst),
        .we(rf_we), .waddr(RW'(dec.rsel)), .wdata(res),
        .raddr(RW'(dec.rsel)), .rdata(racc)
    );

    cpu_alu #(.DW(DW)) u_alu (
        .op(dec.op), .a(racc), .b(opnd), .y(alu_y)
    );

    cpu_bus_port #(.AW(AW), .DW(DW)) u_bus (
        .clk(clk), .rst(rst),
        .go(go), .we_in(go_we), .addr_in(go_addr), .wdata_in(racc),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .done(done)
    );

    always_comb begin
        go      = 1'b0;
        go_we   = 1'b0;
        go_addr = pc;
        case (phase)
            PH_FETCH_OP, PH_FETCH_ADR: go = 1'b1;
            PH_OPERAND: begin
                go      = 1'b1;
                go_addr = AW'(adr);
            end
            PH_WRITE: begin
                go      = dec.writes_mem;
                go_we   = dec.writes_mem;
                go_addr = AW'(adr);
            end
            default: go = 1'b0;
        endcase
    end

    assign rf_we = (phase == PH_WRITE) && dec.writes_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH_OP;
            pc    <= '0;
            ir    <= '0;
            adr   <= '0;
            opnd  <= '0;
            res   <= '0;
            fault <= 1'b0;
        end else begin
            case (phase)
                PH_FETCH_OP: if (done) begin
                    ir    <= bus_rdata[7:0];
                    pc    <= pc + AW'(1);
                    phase <= PH_FETCH_ADR;
                end
                PH_FETCH_ADR: if (done) begin
                    adr   <= bus_rdata[7:0];
                    pc    <= pc + AW'(1);
                    phase <= PH_DECODE;
                end
                PH_DECODE: begin
                    if (!dec.valid) begin
                        fault <= 1'b1;
                        phase <= PH_HALT;
                    end else if (dec.needs_operand) begin
                        phase <= PH_OPERAND;
                    end else begin
                        phase <= PH_EXECUTE;
                    end
                end
                PH_OPERAND: if (done) begin
                    opnd  <= bus_rdata;
                    phase <= PH_EXECUTE;
                end
                PH_EXECUTE: begin
                    res <= alu_y;
                    if (dec.is_jump) pc <= AW'(adr);
                    phase <= PH_WRITE;
                end
                PH_WRITE: begin
                    if (!dec.writes_mem || done) phase <= PH_FETCH_OP;
                end
                default: phase <= PH_HALT;
            endcase
        end
    end

    // R11: fault is sticky until reset
    p_fault_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R11: a faulted processor stays off the bus
    p_fault_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        fault |-> !bus_req);

    // R2: each fetched instruction byte advances the program counter by one
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !bus_we && (phase == PH_FETCH_OP || phase == PH_FETCH_ADR))
            |=> (pc == $past(pc) + AW'(1)));

    // R4: the operand read never starts in the cycle right after the address byte arrives
    p_operand_serial_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH_ADR && done) |=> !bus_req);

    // R9: a store is the only source of a write transaction
    p_write_only_store_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |-> (phase == PH_WRITE));
endmodule

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_req, bus_we, bus_ack, fault;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;

    logic [7:0] mem [256];
    logic [7:0] img [256];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [7:0] log_addr [64];
    logic       log_we   [64];
    int         log_n    = 0;
    int         gap_bad  = 0;
    int         req_seen = 0;
    logic       prev_done = 1'b0;

    always #2.5 clk = ~clk;

    acc_cpu u0 (
        .clk(clk), .rst(rst),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .fault(fault)
    );

    assign bus_rdata = mem[bus_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            bus_ack <= 1'b0;
            mem     <= img;
        end else begin
            bus_ack <= bus_req && !bus_ack;
            if (bus_req && bus_ack && bus_we) mem[bus_addr] <= bus_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            log_n     = 0;
            gap_bad   = 0;
            req_seen  = 0;
            prev_done = 1'b0;
        end else begin
            if (prev_done && bus_req) gap_bad++;
            if (bus_req) req_seen++;
            if (bus_req && bus_ack && log_n < 64) begin
                log_addr[log_n] = bus_addr;
                log_we[log_n]   = bus_we;
                log_n++;
            end
            prev_done = bus_req && bus_ack;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int cycles);
        do_reset();
        repeat (cycles) @(negedge clk);
    endtask

    // {op nibble, reg1 value, memory byte, expected reg1}
    localparam logic [27:0] VEC [8] = '{
        {4'h7, 8'h10, 8'h55, 8'h65},
        {4'h7, 8'hFF, 8'h02, 8'h01},
        {4'h8, 8'h03, 8'h05, 8'hFE},
        {4'h8, 8'h80, 8'h01, 8'h7F},
        {4'h9, 8'hF0, 8'h3C, 8'h30},
        {4'hA, 8'hF0, 8'h0C, 8'hFC},
        {4'hB, 8'hAA, 8'hFF, 8'h55},
        {4'h1, 8'h33, 8'h5A, 8'h5A}
    };

    function automatic string vec_tag(input logic [3:0] op);
        case (op)
            4'h7: return "R5 add";
            4'h8: return "R7 sub";
            4'h1: return "R9 load";
            default: return "R8 logic";
        endcase
    endfunction

    initial begin
        // R1: reset state at the ports, registers cleared
        clear_img();
        img[8'h00] = 8'h23; img[8'h01] = 8'h90;
        img[8'h02] = 8'h22; img[8'h03] = 8'h91;
        img[8'h04] = 8'h42; img[8'h05] = 8'h04;
        img[8'h90] = 8'hAA; img[8'h91] = 8'hBB;
        do_reset();
        check(bus_req == 1'b1 && bus_we == 1'b0, "R1 first request is a read", {bus_req, bus_we}, 2'b10);
        check(bus_addr == 8'h00, "R1 first address", bus_addr, 0);
        check(fault == 1'b0, "R1 fault clear", fault, 0);
        repeat (120) @(negedge clk);
        check(mem[8'h90] == 8'h00, "R1 reg1 cleared", mem[8'h90], 0);
        check(mem[8'h91] == 8'h00, "R1 reg0 cleared", mem[8'h91], 0);

        // R5 R7 R8 R9: vector table through load / op / store / jump
        for (int v = 0; v < 8; v++) begin
            clear_img();
            img[8'h00] = 8'h13;                    img[8'h01] = 8'h80;
            img[8'h02] = {VEC[v][27:24], 4'h3};   img[8'h03] = 8'h81;
            img[8'h04] = 8'h23;                    img[8'h05] = 8'h82;
            img[8'h06] = 8'h42;                    img[8'h07] = 8'h06;
            img[8'h80] = VEC[v][23:16];
            img[8'h81] = VEC[v][15:8];
            run(150);
            check(mem[8'h82] == VEC[v][7:0], vec_tag(VEC[v][27:24]), mem[8'h82], VEC[v][7:0]);
        end

        // R2 R3 R4 R5 R9 R10: exact transaction order around the 0x73 add
        clear_img();
        img[8'h00] = 8'h13; img[8'h01] = 8'h21;
        img[8'h02] = 8'h73; img[8'h03] = 8'h20;
        img[8'h04] = 8'h23; img[8'h05] = 8'h30;
        img[8'h06] = 8'h42; img[8'h07] = 8'h06;
        img[8'h20] = 8'h55; img[8'h21] = 8'h10;
        run(150);
        begin
            logic [7:0] ea [12] = '{8'h00, 8'h01, 8'h21, 8'h02, 8'h03, 8'h20,
                                   8'h04, 8'h05, 8'h30, 8'h06, 8'h07, 8'h06};
            logic       ew [12] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0};
            int bad = 0;
            int first = -1;
            for (int i = 0; i < 12; i++) begin
                if (log_addr[i] !== ea[i] || log_we[i] !== ew[i]) begin
                    bad++;
                    if (first < 0) first = i;
                end
            end
            check(log_n >= 12, "R2 transaction count", log_n, 12);
            check(bad == 0, "R4 R10 transaction order",
                  (first < 0) ? 0 : log_addr[first], (first < 0) ? 0 : ea[first]);
        end
        check(mem[8'h30] == 8'h65, "R5 opcode 0x73 sum", mem[8'h30], 8'h65);
        check(gap_bad == 0, "R3 idle cycle after acknowledge", gap_bad, 0);
        check(fault == 1'b0, "R6 valid program no fault", fault, 0);

        // R12: register independence
        clear_img();
        img[8'h00] = 8'h12; img[8'h01] = 8'h80;
        img[8'h02] = 8'h13; img[8'h03] = 8'h81;
        img[8'h04] = 8'h72; img[8'h05] = 8'h80;
        img[8'h06] = 8'h23; img[8'h07] = 8'h82;
        img[8'h08] = 8'h22; img[8'h09] = 8'h83;
        img[8'h0A] = 8'h42; img[8'h0B] = 8'h0A;
        img[8'h80] = 8'h05; img[8'h81] = 8'h09;
        run(200);
        check(mem[8'h82] == 8'h09, "R12 reg1 untouched", mem[8'h82], 8'h09);
        check(mem[8'h83] == 8'h0A, "R12 reg0 updated", mem[8'h83], 8'h0A);

        // R11 R6: undefined opcodes halt and stay off the bus
        begin
            logic [7:0] badop [3] = '{8'h53, 8'h77, 8'h03};
            for (int k = 0; k < 3; k++) begin
                clear_img();
                img[8'h00] = 8'h13;     img[8'h01] = 8'h80;
                img[8'h02] = badop[k];  img[8'h03] = 8'h40;
                img[8'h04] = 8'h23;     img[8'h05] = 8'h82;
                img[8'h80] = 8'h44;     img[8'h82] = 8'hEE;
                run(60);
                check(fault == 1'b1, "R11 fault raised", fault, 1);
                req_seen = 0;
                repeat (30) @(negedge clk);
                check(req_seen == 0 && fault == 1'b1, "R11 halted and quiet", req_seen, 0);
                check(mem[8'h82] == 8'hEE, "R6 no store after bad opcode", mem[8'h82], 8'hEE);
            end
        end
        do_reset();
        check(fault == 1'b0, "R11 reset clears fault", fault, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule